// File: doc/BRIEF.md
# I2C Byte-Level Control Core with Direction Tracking

This block is the control core of a byte-oriented I2C port that can act either as bus master or as addressed slave. A processor issues a command word of four bits (mode, direction, busy, pending). One combination of these bits launches a START followed by a stored address byte. Another, valid only while the bus is busy, launches a STOP. The core drives the two bus lines through active-high pull-down enables and reads them back through a synchroniser. It watches the bus for START and STOP conditions to keep a bus-busy flag.

The direction flag says whether the port sends or receives. Software writes it with every command, and the hardware rewrites it after the address phase. In master mode the flag takes the inverse of the R/W bit that was sent, but only once the addressed device has acknowledged. In slave mode it takes the received R/W bit when the address matches the own address or is the all-zero broadcast. A detected STOP clears it. A free-data mode turns off every kind of address recognition. The SCL half-period is set by a divider input.

Top module: `i2c_ctl_core`

## Requirements
- R1: `bus_busy` goes to 1 after a START on the lines (SDA falling while SCL is high) and returns to 0 after a STOP (SDA rising while SCL is high). It reads 0 after reset.
- R2: A command with mode, direction, busy and pending all 1, issued while `bus_busy` is 0 and `ack_en` is 1, produces a START. The core then sends the eight bits of `tgt_byte` MSB first, one per SCL high phase, with the R/W bit in the eighth position. In the ninth SCL high phase it releases SDA. The same command with `ack_en` at 0 leaves both lines released.
- R3: A command with mode, direction and pending at 1 and busy at 0, issued while `bus_busy` is 1, produces a STOP that ends the transfer.
- R4: If another device holds SCL low when a STOP is requested, the core keeps SDA low and produces no STOP until SCL is released.
- R5: In slave mode (mode bit 0), a received address byte whose upper seven bits equal `own_addr` sets `dir_tx` to the received R/W bit. With `ack_en` at 1 the core pulls SDA low during the ninth clock.
- R6: In slave mode, a received byte of all zeros (broadcast) sets `dir_tx` to 0 and is acknowledged in the same way.
- R7: In slave mode, a non-matching address byte leaves `dir_tx` unchanged and gets no acknowledge.
- R8: In master mode, once the ninth clock samples an acknowledge (SDA low), `dir_tx` becomes the inverse of the sent R/W bit.
- R9: In master mode, if the ninth clock samples no acknowledge, `dir_tx` keeps its value.
- R10: With `free_fmt` at 1, the hardware does not change `dir_tx` after the first byte in either mode, and the slave gives no acknowledge.
- R11: A detected STOP clears `dir_tx` to 0.
- R12: While the master drives SCL, each SCL high phase lasts `half_div`+1 clock cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cmd_wr | input | 1 | One-cycle strobe that writes the command bits |
| cmd_mst | input | 1 | Mode bit: 1 master, 0 slave |
| cmd_trx | input | 1 | Direction bit written by software |
| cmd_bb | input | 1 | Busy bit of the command (1 start, 0 stop) |
| cmd_pin | input | 1 | Pending bit of the command |
| ack_en | input | 1 | Acknowledge enable |
| free_fmt | input | 1 | Free-data mode: no address recognition |
| own_addr | input | ADDR_W | Own slave address |
| tgt_byte | input | ADDR_W+1 | Address and R/W byte sent after START |
| half_div | input | DIV_W | SCL half-period minus one, in clock cycles |
| scl_in | input | 1 | SCL line level |
| sda_in | input | 1 | SDA line level |
| scl_pull | output | 1 | 1 pulls SCL low |
| sda_pull | output | 1 | 1 pulls SDA low |
| bus_busy | output | 1 | Bus-busy flag |
| dir_tx | output | 1 | Direction flag: 1 transmit, 0 receive |
| mode_master | output | 1 | Stored mode bit |

## Verification
The hardest case to reach from the ports is a STOP request that arrives while a foreign device is stretching SCL. The bench reaches it as follows: it completes an address phase, asserts its own pull on SCL, issues the stop command, and then watches SDA stay low and the busy flag stay set for many half-periods before it lets go. The slave-side direction rules need a second master on the bus. The bench plays that master with its own pull-downs and sends matching, foreign, broadcast and free-mode bytes. It samples SDA in the ninth high phase to see whether the core acknowledged.

// File: rtl/i2cc_pkg.sv
// Shared types for the I2C control core.
// Assumes 7-bit addressing plus one R/W bit per address byte.
package i2cc_pkg;
    typedef enum logic [2:0] {
        M_IDLE, M_START, M_BLO, M_BHI, M_HOLD, M_PLO, M_PWAIT, M_PREL
    } mst_st_t;

    typedef enum logic [2:0] {
        S_IDLE, S_SHIFT, S_ACKW, S_ACKLO, S_ACKHI, S_DONE
    } slv_st_t;
endpackage

// File: rtl/i2cc_line_mon.sv
// Line monitor: synchronises SCL/SDA through STAGES flops, flags SCL edges
// and START/STOP conditions, and keeps the bus-busy flag.
// Assumes STAGES >= 2 and idle lines read high.
module i2cc_line_mon #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_in,
    input  logic sda_in,
    output logic scl_s,
    output logic sda_s,
    output logic scl_rise,
    output logic scl_fall,
    output logic start_det,
    output logic stop_det,
    output logic busy
);
    logic [STAGES-1:0] scl_ch, sda_ch;
    logic scl_q, sda_q;

    for (genvar g = 0; g < STAGES; g++) begin : g_sync
        if (g == 0) begin : g_first
            // first stage captures the raw lines
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    scl_ch[g] <= 1'b1;
                    sda_ch[g] <= 1'b1;
                end else begin
                    scl_ch[g] <= scl_in;
                    sda_ch[g] <= sda_in;
                end
            end
        end else begin : g_next
            // later stages pass the previous one on
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    scl_ch[g] <= 1'b1;
                    sda_ch[g] <= 1'b1;
                end else begin
                    scl_ch[g] <= scl_ch[g-1];
                    sda_ch[g] <= sda_ch[g-1];
                end
            end
        end
    end

    assign scl_s = scl_ch[STAGES-1];
    assign sda_s = sda_ch[STAGES-1];

    // one-cycle history of the synchronised lines
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            scl_q <= 1'b1;
            sda_q <= 1'b1;
        end else begin
            scl_q <= scl_s;
            sda_q <= sda_s;
        end
    end

    assign scl_rise  = scl_s & ~scl_q;
    assign scl_fall  = ~scl_s & scl_q;
    assign start_det = scl_s & scl_q & sda_q & ~sda_s;
    assign stop_det  = scl_s & scl_q & ~sda_q & sda_s;

    // busy flag follows START and STOP on the bus
    always_ff @(posedge clk) begin
        if (!rst_n)         busy <= 1'b0;
        else if (start_det) busy <= 1'b1;
        else if (stop_det)  busy <= 1'b0;
    end

    AST_BUSY_AFTER_START: assert property (@(posedge clk) disable iff (!rst_n)
        start_det |=> busy); // R1
    AST_IDLE_AFTER_STOP: assert property (@(posedge clk) disable iff (!rst_n)
        stop_det |=> !busy); // R1
endmodule

// File: rtl/i2cc_tick.sv
// Half-period tick generator: pulses every div+1 cycles while run is high,
// restarting from zero whenever run drops.
module i2cc_tick #(
    parameter int DIV_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic [DIV_W-1:0] div,
    output logic             tick
);
    logic [DIV_W-1:0] cnt;

    assign tick = run && (cnt == div);

    // count up to div, wrap on the tick
    always_ff @(posedge clk) begin
        if (!rst_n || !run) cnt <= '0;
        else if (tick)      cnt <= '0;
        else                cnt <= cnt + 1'b1;
    end
endmodule

// File: rtl/i2cc_master_seq.sv
// Master sequencer: START, address byte MSB first with R/W last, ninth clock
// with SDA released to sample the acknowledge, then holds SCL low until a
// STOP request. The STOP waits for SCL to be released by other devices.
// SDA changes one cycle after SCL so no false START/STOP appears.
module i2cc_master_seq #(
    parameter int ADDR_W = 7
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_go,
    input  logic              stop_go,
    input  logic [ADDR_W:0]   addr_byte,
    input  logic              tick,
    input  logic              scl_s,
    input  logic              sda_s,
    output logic              run,
    output logic              scl_pull,
    output logic              sda_pull,
    output logic              done,
    output logic              acked,
    output logic              rw_sent
);
    import i2cc_pkg::*;
    localparam int BYTE_BITS = ADDR_W + 1;
    localparam int CNT_W = $clog2(BYTE_BITS + 1);
    localparam logic [CNT_W-1:0] LAST = CNT_W'(BYTE_BITS);

    mst_st_t state;
    logic [BYTE_BITS-1:0] sh;
    logic [CNT_W-1:0] bit_idx;
    logic stop_pend;
    logic pull_nx;

    assign run      = (state != M_IDLE);
    assign scl_pull = (state == M_BLO) || (state == M_HOLD) || (state == M_PLO);

    // SDA pull level wanted by the current state
    always_comb begin
        case (state)
            M_START, M_PLO, M_PWAIT: pull_nx = 1'b1;
            M_BLO:   pull_nx = (bit_idx == LAST) ? 1'b0 : ~sh[BYTE_BITS-1];
            M_BHI:   pull_nx = sda_pull;
            default: pull_nx = 1'b0;
        endcase
    end

    // SDA driver lags the state by one cycle
    always_ff @(posedge clk) begin
        if (!rst_n) sda_pull <= 1'b0;
        else        sda_pull <= pull_nx;
    end

    // remembers a STOP request until the hold state can act on it
    always_ff @(posedge clk) begin
        if (!rst_n || state == M_IDLE || state == M_PLO) stop_pend <= 1'b0;
        else if (stop_go)                               stop_pend <= 1'b1;
    end

    // sequence state, bit counter and shift register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state   <= M_IDLE;
            sh      <= '0;
            bit_idx <= '0;
            done    <= 1'b0;
            acked   <= 1'b0;
            rw_sent <= 1'b0;
        end else begin
            done <= 1'b0;
            case (state)
                M_IDLE: if (start_go) begin
                    state   <= M_START;
                    sh      <= addr_byte;
                    rw_sent <= addr_byte[0];
                    bit_idx <= '0;
                end
                M_START: if (tick) state <= M_BLO;
                M_BLO:   if (tick) state <= M_BHI;
                M_BHI: if (tick) begin
                    if (bit_idx == LAST) begin
                        state <= M_HOLD;
                        done  <= 1'b1;
                        acked <= ~sda_s;
                    end else begin
                        state   <= M_BLO;
                        bit_idx <= bit_idx + 1'b1;
                        sh      <= {sh[BYTE_BITS-2:0], 1'b0};
                    end
                end
                M_HOLD:  if (tick && stop_pend) state <= M_PLO;
                M_PLO:   if (tick) state <= M_PWAIT;
                M_PWAIT: if (tick && scl_s) state <= M_PREL;
                M_PREL:  if (tick) state <= M_IDLE;
                default: state <= M_IDLE;
            endcase
        end
    end

    AST_SDA_STEADY_SCL_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
        (state == M_BHI && $past(state) == M_BHI) |-> $stable(sda_pull)); // R2
    AST_STOP_HELD_WHILE_SCL_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        (state == M_PWAIT && !scl_s) |=> (state == M_PWAIT && sda_pull)); // R4
endmodule

// File: rtl/i2cc_slave_rx.sv
// Slave address receiver: after each START it shifts in the first byte on
// SCL rising edges, compares it with the own address or the all-zero
// broadcast, reports a hit with the R/W bit and drives the acknowledge
// through the ninth clock. Disabled while the core is in master mode.
module i2cc_slave_rx #(
    parameter int ADDR_W = 7
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              enable,
    input  logic              free_fmt,
    input  logic              ack_en,
    input  logic [ADDR_W-1:0] own_addr,
    input  logic              scl_rise,
    input  logic              scl_fall,
    input  logic              sda_s,
    input  logic              start_det,
    input  logic              stop_det,
    output logic              hit,
    output logic              hit_rw,
    output logic              ack_pull
);
    import i2cc_pkg::*;
    localparam int BYTE_BITS = ADDR_W + 1;
    localparam int CNT_W = $clog2(BYTE_BITS);
    localparam logic [CNT_W-1:0] LAST = CNT_W'(BYTE_BITS - 1);

    slv_st_t state;
    logic [BYTE_BITS-2:0] shreg;
    logic [CNT_W-1:0] cnt;
    logic [BYTE_BITS-1:0] byte_now;
    logic match;

    assign byte_now = {shreg, sda_s};
    assign match    = !free_fmt &&
                      ((byte_now[BYTE_BITS-1:1] == own_addr) || (byte_now == '0));
    assign ack_pull = (state == S_ACKLO) || (state == S_ACKHI);

    // receive, compare and acknowledge the first byte after START
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state  <= S_IDLE;
            shreg  <= '0;
            cnt    <= '0;
            hit    <= 1'b0;
            hit_rw <= 1'b0;
        end else begin
            hit <= 1'b0;
            if (!enable || stop_det) begin
                state <= S_IDLE;
            end else if (start_det) begin
                state <= S_SHIFT;
                cnt   <= '0;
            end else begin
                case (state)
                    S_SHIFT: if (scl_rise) begin
                        shreg <= byte_now[BYTE_BITS-2:0];
                        if (cnt == LAST) begin
                            hit    <= match;
                            hit_rw <= sda_s;
                            state  <= (match && ack_en) ? S_ACKW : S_DONE;
                        end else begin
                            cnt <= cnt + 1'b1;
                        end
                    end
                    S_ACKW:  if (scl_fall) state <= S_ACKLO;
                    S_ACKLO: if (scl_rise) state <= S_ACKHI;
                    S_ACKHI: if (scl_fall) state <= S_DONE;
                    default: ;
                endcase
            end
        end
    end

    AST_SLAVE_QUIET_AS_MASTER: assert property (@(posedge clk) disable iff (!rst_n)
        !enable |=> !ack_pull); // R7
endmodule

// File: rtl/i2c_ctl_core.sv
// Top of the I2C control core. Decodes the four-bit command into START and
// STOP requests, holds mode and direction flags, and applies the hardware
// rules that rewrite the direction after the address phase.
// Assumes scl_in/sda_in are the wired-AND line levels.
module i2c_ctl_core #(
    parameter int ADDR_W      = 7,
    parameter int DIV_W       = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cmd_wr,
    input  logic              cmd_mst,
    input  logic              cmd_trx,
    input  logic              cmd_bb,
    input  logic              cmd_pin,
    input  logic              ack_en,
    input  logic              free_fmt,
    input  logic [ADDR_W-1:0] own_addr,
    input  logic [ADDR_W:0]   tgt_byte,
    input  logic [DIV_W-1:0]  half_div,
    input  logic              scl_in,
    input  logic              sda_in,
    output logic              scl_pull,
    output logic              sda_pull,
    output logic              bus_busy,
    output logic              dir_tx,
    output logic              mode_master
);
    logic scl_s, sda_s, scl_rise, scl_fall, start_det, stop_det;
    logic m_run, m_tick, m_scl, m_sda, m_done, m_acked, m_rw;
    logic s_hit, s_rw, s_ack;
    logic start_go, stop_go, m_upd, s_upd;

    i2cc_line_mon #(.STAGES(SYNC_STAGES)) u_mon (
        .clk(clk), .rst_n(rst_n), .scl_in(scl_in), .sda_in(sda_in),
        .scl_s(scl_s), .sda_s(sda_s), .scl_rise(scl_rise), .scl_fall(scl_fall),
        .start_det(start_det), .stop_det(stop_det), .busy(bus_busy)
    );

    i2cc_tick #(.DIV_W(DIV_W)) u_tick (
        .clk(clk), .rst_n(rst_n), .run(m_run), .div(half_div), .tick(m_tick)
    );

    i2cc_master_seq #(.ADDR_W(ADDR_W)) u_mst (
        .clk(clk), .rst_n(rst_n), .start_go(start_go), .stop_go(stop_go),
        .addr_byte(tgt_byte), .tick(m_tick), .scl_s(scl_s), .sda_s(sda_s),
        .run(m_run), .scl_pull(m_scl), .sda_pull(m_sda), .done(m_done),
        .acked(m_acked), .rw_sent(m_rw)
    );

    i2cc_slave_rx #(.ADDR_W(ADDR_W)) u_slv (
        .clk(clk), .rst_n(rst_n), .enable(!mode_master), .free_fmt(free_fmt),
        .ack_en(ack_en), .own_addr(own_addr), .scl_rise(scl_rise),
        .scl_fall(scl_fall), .sda_s(sda_s), .start_det(start_det),
        .stop_det(stop_det), .hit(s_hit), .hit_rw(s_rw), .ack_pull(s_ack)
    );

    assign start_go = cmd_wr & cmd_mst & cmd_trx & cmd_bb & cmd_pin & ack_en & !bus_busy;
    assign stop_go  = cmd_wr & cmd_mst & cmd_trx & !cmd_bb & cmd_pin & bus_busy;
    assign m_upd    = m_done & m_acked & mode_master & !free_fmt;
    assign s_upd    = s_hit & !free_fmt;
    assign scl_pull = m_scl;
    assign sda_pull = m_sda | s_ack;

    // mode flag is set only by software
    always_ff @(posedge clk) begin
        if (!rst_n)      mode_master <= 1'b0;
        else if (cmd_wr) mode_master <= cmd_mst;
    end

    // direction flag: software write, STOP clear, then address-phase rules
    always_ff @(posedge clk) begin
        if (!rst_n)        dir_tx <= 1'b0;
        else if (cmd_wr)   dir_tx <= cmd_trx;
        else if (stop_det) dir_tx <= 1'b0;
        else if (m_upd)    dir_tx <= ~m_rw;
        else if (s_upd)    dir_tx <= s_rw;
    end

    AST_TRX_ZERO_AFTER_STOP: assert property (@(posedge clk) disable iff (!rst_n)
        (stop_det && !cmd_wr) |=> !dir_tx); // R11
    AST_FREE_KEEPS_TRX: assert property (@(posedge clk) disable iff (!rst_n)
        (free_fmt && !cmd_wr && !stop_det) |=> $stable(dir_tx)); // R10
    AST_NACK_KEEPS_TRX: assert property (@(posedge clk) disable iff (!rst_n)
        (m_done && !m_acked && !cmd_wr && !stop_det && !s_upd) |=> $stable(dir_tx)); // R9
endmodule

// File: tb/tb_i2c_ctl_core.sv
// Scoreboard bench: the driver queues the SDA levels expected in each SCL
// high phase of a master transfer; the monitor pops and compares them.
// The bench also plays the remote slave (acknowledge) and a remote master.
module tb_i2c_ctl_core;
    localparam int CLK_PERIOD = 10;
    localparam int HALF = 9;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic cmd_wr = 0, cmd_mst = 0, cmd_trx = 0, cmd_bb = 0, cmd_pin = 0;
    logic ack_en = 1, free_fmt = 0;
    logic [6:0] own_addr = 7'h2C;
    logic [7:0] tgt_byte = 8'h00;
    logic [7:0] half_div = 8'(HALF);
    logic scl_pull, sda_pull, bus_busy, dir_tx, mode_master;
    logic m_scl_low = 0, m_sda_low = 0, ack_low = 0;
    wire  scl_line = !(scl_pull | m_scl_low);
    wire  sda_line = !(sda_pull | m_sda_low | ack_low);

    int n_chk = 0, n_bad = 0, cyc = 0, hi_t0 = 0, mon_cnt = 0;
    logic mon_en = 0, mon_ack = 0;
    logic exp_q[$];

    i2c_ctl_core dut (
        .clk(clk), .rst_n(rst_n), .cmd_wr(cmd_wr), .cmd_mst(cmd_mst),
        .cmd_trx(cmd_trx), .cmd_bb(cmd_bb), .cmd_pin(cmd_pin), .ack_en(ack_en),
        .free_fmt(free_fmt), .own_addr(own_addr), .tgt_byte(tgt_byte),
        .half_div(half_div), .scl_in(scl_line), .sda_in(sda_line),
        .scl_pull(scl_pull), .sda_pull(sda_pull), .bus_busy(bus_busy),
        .dir_tx(dir_tx), .mode_master(mode_master)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic idle(int n);
        repeat (n) @(negedge clk);
    endtask

    // watchdog and cycle counter
    always @(posedge clk) begin
        cyc = cyc + 1;
        if (cyc > 150000) begin
            n_bad++;
            $display("FAIL watchdog actual=%0d expected<150000", cyc);
            $display("test done: total=%0d bad=%0d", n_chk, n_bad);
            $finish;
        end
    end

    // monitor: compares SDA in each SCL high phase with the scoreboard queue
    always @(posedge scl_line) begin
        if (mon_en) begin
            mon_cnt = mon_cnt + 1;
            hi_t0 = cyc;
            if (mon_cnt <= 9) begin
                n_chk++;
                if (exp_q.size() == 0) begin
                    n_bad++;
                    $display("FAIL R2 actual=extra_bit expected=none");
                end else begin
                    logic e;
                    e = exp_q.pop_front();
                    if (sda_line !== e) begin
                        n_bad++;
                        $display("FAIL R2 bit%0d actual=%0b expected=%0b", mon_cnt, sda_line, e);
                    end
                end
            end
        end
    end

    // remote slave: acknowledge in the ninth clock; R12 high-phase length
    always @(negedge scl_line) begin
        if (mon_en) begin
            if (mon_cnt == 1) chk("R12 high phase", 32'(cyc - hi_t0), 32'(HALF + 1));
            if (mon_cnt == 8) ack_low = mon_ack;
            if (mon_cnt == 9) ack_low = 1'b0;
        end
    end

    task automatic cmd(logic m, logic t, logic b, logic p);
        @(negedge clk);
        cmd_mst = m; cmd_trx = t; cmd_bb = b; cmd_pin = p; cmd_wr = 1;
        @(negedge clk);
        cmd_wr = 0;
    endtask

    // driver: queue expected bits then start a master address phase
    task automatic mxfer(logic [7:0] b, logic ack);
        tgt_byte = b;
        mon_cnt = 0;
        mon_ack = ack;
        for (int i = 7; i >= 0; i--) exp_q.push_back(b[i]);
        exp_q.push_back(!ack);
        mon_en = 1;
        cmd(1, 1, 1, 1);
        idle(20 * (HALF + 1) + 60);
        chk("R2 queue drained", 32'(exp_q.size()), 0);
        mon_en = 0;
    endtask

    task automatic mstop();
        cmd(1, 1, 0, 1);
        idle(8 * (HALF + 1));
        chk("R3 busy after stop", bus_busy, 0);
        chk("R11 dir after stop", dir_tx, 0);
    endtask

    // remote master helpers for slave tests
    task automatic rm_start();
        m_sda_low = 1; idle(10); m_scl_low = 1; idle(10);
    endtask

    task automatic rm_byte(logic [7:0] b, output logic got_ack);
        for (int i = 7; i >= 0; i--) begin
            m_sda_low = !b[i]; idle(10);
            m_scl_low = 0; idle(10);
            m_scl_low = 1; idle(5);
        end
        m_sda_low = 0; idle(10);
        m_scl_low = 0; idle(5);
        got_ack = !sda_line; idle(5);
        m_scl_low = 1; idle(10);
    endtask

    task automatic rm_stop();
        m_sda_low = 1; idle(10);
        m_scl_low = 0; idle(10);
        m_sda_low = 0; idle(20);
    endtask

    initial begin
        logic ak;
        idle(5);
        rst_n = 1;
        idle(2);
        chk("R1 reset busy", bus_busy, 0);
        chk("R2 reset scl_pull", scl_pull, 0);
        chk("R2 reset sda_pull", sda_pull, 0);
        chk("R11 reset dir", dir_tx, 0);

        // start command ignored without acknowledge enable
        ack_en = 0;
        cmd(1, 1, 1, 1);
        idle(100);
        chk("R2 no start busy", bus_busy, 0);
        chk("R2 no start scl", scl_line, 1);
        ack_en = 1;

        // master, R/W=1, acknowledged -> receive
        mxfer(8'hA7, 1);
        chk("R1 busy after start", bus_busy, 1);
        chk("R8 dir after ack rw1", dir_tx, 0);

        // stop while another device stretches SCL
        m_scl_low = 1;
        cmd(1, 1, 0, 1);
        idle(20 * (HALF + 1));
        chk("R4 busy held", bus_busy, 1);
        chk("R4 sda held low", sda_line, 0);
        m_scl_low = 0;
        idle(8 * (HALF + 1));
        chk("R3 busy after stop", bus_busy, 0);
        chk("R3 sda released", sda_line, 1);
        chk("R11 dir cleared", dir_tx, 0);

        // master, R/W=0, acknowledged -> transmit
        mxfer(8'hA6, 1);
        chk("R8 dir after ack rw0", dir_tx, 1);
        mstop();

        // master, no acknowledge -> unchanged
        mxfer(8'hA7, 0);
        chk("R9 dir kept on nack", dir_tx, 1);
        mstop();

        // master in free-data mode -> unchanged
        free_fmt = 1;
        mxfer(8'hA7, 1);
        chk("R10 master free dir", dir_tx, 1);
        mstop();
        free_fmt = 0;

        // slave: own address with R/W=1
        cmd(0, 0, 0, 0);
        rm_start();
        rm_byte({7'h2C, 1'b1}, ak);
        chk("R5 ack on match", ak, 1);
        chk("R5 dir from rw", dir_tx, 1);
        chk("R1 busy slave", bus_busy, 1);
        rm_stop();
        chk("R1 busy clear slave", bus_busy, 0);
        chk("R11 dir clear slave", dir_tx, 0);

        // slave: foreign address
        cmd(0, 1, 0, 0);
        rm_start();
        rm_byte({7'h30, 1'b0}, ak);
        chk("R7 no ack mismatch", ak, 0);
        chk("R7 dir kept", dir_tx, 1);
        rm_stop();

        // slave: broadcast byte
        cmd(0, 1, 0, 0);
        rm_start();
        rm_byte(8'h00, ak);
        chk("R6 ack broadcast", ak, 1);
        chk("R6 dir cleared", dir_tx, 0);
        rm_stop();

        // slave in free-data mode
        free_fmt = 1;
        cmd(0, 0, 0, 0);
        rm_start();
        rm_byte({7'h2C, 1'b1}, ak);
        chk("R10 no ack free", ak, 0);
        chk("R10 slave free dir", dir_tx, 0);
        rm_stop();
        free_fmt = 0;

        $display("test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end
endmodule